// File: doc/BRIEF.md
# Cascaded Interrupt Status Encoder

This block gathers interrupt requests from three tiers (critical, main and peripheral) and condenses them into one status word. Software reads that word to learn which tier is active and which source inside the tier won. Each tier has a mask register in which a set bit disables a source. Within a tier, the lowest-numbered unmasked pending source wins.

A fourth group of DMA-task sources sits behind peripheral slot 0. DMA requests are latched in a sticky pending register, and software clears that register by writing ones. Peripheral sources are split into a high class and a low class by a class register. A pending high-class source raises critical slot 2. A pending low-class source raises main slot 4. In both cases the real source number appears in the peripheral field, so software can follow it there.

Software reaches all registers through a simple read/write port. The CPU sees only a registered interrupt output and a registered critical output.

Top module: `irq_status_enc`

## Requirements
- R1: After a synchronous reset:
  - the critical mask reads 0xF, the main mask reads 0x00010FFF, the peripheral mask reads 0x7FFFFC00 and the DMA mask reads 0xFFFFFFFF;
  - DMA pending and the class register read 0;
  - irq_o and crit_o are 0.
- R2: The status word has the following layout:
  - bit 10 is the critical flag, with the critical index in bits 9:8;
  - bit 21 is the main flag, with the main index in bits 20:16;
  - bit 29 is the peripheral flag, with the peripheral index in bits 28:24;
  - all other bits read 0, and an index reads 0 while its flag is clear.
- R3: Mask bits disable sources as follows, and in every mask a set bit disables:
  - critical mask bit n disables critical source n;
  - main mask bit (16−n) disables main source n;
  - peripheral mask bit (31−n) disables peripheral source n;
  - DMA mask bit n disables DMA source n.
- R4: Within each tier, the lowest-numbered unmasked pending source is reported.
- R5: The crit_req bit 2, main_req bit 4 and per_req bit 0 inputs have no effect. Those slots are driven internally.
- R6: The class register (address 6) sets the class of peripheral source n:
  - class bit n = 1 makes peripheral source n high class. An unmasked pending high-class source raises critical slot 2.
  - An unmasked pending low-class source raises main slot 4.
  - The peripheral field reports the lowest high-class winner if there is one, otherwise the lowest low-class winner.
- R7: Peripheral slot 0 is pending exactly when some DMA pending bit is set and its DMA mask bit is clear.
- R8: DMA pending behaves as follows:
  - a dma_req bit sets the matching pending bit, which stays set;
  - writing 1 to a pending bit clears it, and writing 0 leaves it unchanged;
  - when a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: irq_o is 1 exactly when any status flag is set. crit_o is 1 exactly when the critical flag is set. Both are registered one cycle behind the status word.
- R10: A read returns the addressed register on rdata in the cycle after rd_en. The addresses are:
  - 0 status, 1 critical mask, 2 main mask, 3 peripheral mask, 4 DMA mask, 5 DMA pending, 6 class;
  - address 7 reads 0;
  - writes to address 0 are ignored, and only implemented mask bits are retained (4 critical, 17 main).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crit_req | input | 4 | Critical tier requests (bit 2 unused) |
| main_req | input | 17 | Main tier requests (bit 4 unused) |
| per_req | input | 32 | Peripheral tier requests (bit 0 unused) |
| dma_req | input | 32 | DMA task request pulses, set pending bits |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq_o | output | 1 | Any tier active |
| crit_o | output | 1 | Critical tier active |

## Verification
The bench builds the block with its default sizes: 4 critical, 17 main, 32 peripheral and 32 DMA sources. These sizes fill every index field of the status word exactly. They therefore bring both redirect slots, the bit-reversed mask ordering at its extremes (main source 16 and peripheral source 31) and the full 32-bit DMA clear pattern within reach of the random stimulus.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int CRIT_FLAG   = 10;
  localparam int CRIT_LSB    = 8;
  localparam int MAIN_FLAG   = 21;
  localparam int MAIN_LSB    = 16;
  localparam int PER_FLAG    = 29;
  localparam int PER_LSB     = 24;
  localparam int CRIT_REDIR  = 2;
  localparam int MAIN_REDIR  = 4;
  localparam int PER_CASCADE = 0;

  localparam logic [31:0] MAIN_MASK_RST = 32'h0001_0FFF;
  localparam logic [31:0] PER_MASK_RST  = 32'h7FFF_FC00;

  typedef enum logic [2:0] {
    RA_STATUS = 3'd0,
    RA_CMASK  = 3'd1,
    RA_MMASK  = 3'd2,
    RA_PMASK  = 3'd3,
    RA_DMASK  = 3'd4,
    RA_DPEND  = 3'd5,
    RA_CLASS  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irq_lowfirst.sv
module irq_lowfirst #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  // R4: reported index is pending and nothing below it is
  a_r4_hit_valid: assert property (@(posedge clk) disable iff (rst)
    hit |-> req[idx]);
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((req & ((N'(1) << idx) - N'(1))) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_enc_pkg::*;
#(
  parameter int N_CRIT = 4,
  parameter int N_MAIN = 17,
  parameter int N_PER  = 32,
  parameter int N_DMA  = 32,
  parameter int DW     = 32,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [N_DMA-1:0]  dma_req,
  input  logic [DW-1:0]     status_d,
  output logic [N_CRIT-1:0] cmask,
  output logic [N_MAIN-1:0] mmask,
  output logic [N_PER-1:0]  pmask,
  output logic [N_DMA-1:0]  dmask,
  output logic [N_DMA-1:0]  dpend,
  output logic [N_PER-1:0]  pclass,
  output logic [DW-1:0]     rdata
);
  logic             wr_pend;
  logic [N_DMA-1:0] clr_bits;

  assign wr_pend  = wr_en && (addr == AW'(RA_DPEND));
  assign clr_bits = wr_pend ? wdata[N_DMA-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmask  <= '1;
      mmask  <= MAIN_MASK_RST[N_MAIN-1:0];
      pmask  <= PER_MASK_RST[N_PER-1:0];
      dmask  <= '1;
      pclass <= '0;
    end else if (wr_en) begin
      if (addr == AW'(RA_CMASK)) cmask  <= wdata[N_CRIT-1:0];
      if (addr == AW'(RA_MMASK)) mmask  <= wdata[N_MAIN-1:0];
      if (addr == AW'(RA_PMASK)) pmask  <= wdata[N_PER-1:0];
      if (addr == AW'(RA_DMASK)) dmask  <= wdata[N_DMA-1:0];
      if (addr == AW'(RA_CLASS)) pclass <= wdata[N_PER-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dpend <= '0;
    else     dpend <= (dpend & ~clr_bits) | dma_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        AW'(RA_STATUS): rdata <= status_d;
        AW'(RA_CMASK):  rdata <= DW'(cmask);
        AW'(RA_MMASK):  rdata <= DW'(mmask);
        AW'(RA_PMASK):  rdata <= DW'(pmask);
        AW'(RA_DMASK):  rdata <= DW'(dmask);
        AW'(RA_DPEND):  rdata <= DW'(dpend);
        AW'(RA_CLASS):  rdata <= DW'(pclass);
        default:        rdata <= '0;
      endcase
    end
  end

  // R8: set requests land, pending bits only fall through a write of ones
  a_r8_set: assert property (@(posedge clk) disable iff (rst)
    (dma_req != '0) |=> ((dpend & $past(dma_req)) == $past(dma_req)));
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    !wr_pend |=> ((dpend & $past(dpend)) == $past(dpend)));
  a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_pend && dma_req == '0) |=> (dpend == ($past(dpend) & ~$past(wdata[N_DMA-1:0]))));
endmodule

// File: rtl/irq_tiers.sv
module irq_tiers
  import irq_enc_pkg::*;
#(
  parameter int N_CRIT = 4,
  parameter int N_MAIN = 17,
  parameter int N_PER  = 32,
  parameter int N_DMA  = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CRIT-1:0] crit_req,
  input  logic [N_MAIN-1:0] main_req,
  input  logic [N_PER-1:0]  per_req,
  input  logic [N_CRIT-1:0] cmask,
  input  logic [N_MAIN-1:0] mmask,
  input  logic [N_PER-1:0]  pmask,
  input  logic [N_DMA-1:0]  dmask,
  input  logic [N_DMA-1:0]  dpend,
  input  logic [N_PER-1:0]  pclass,
  output logic [DW-1:0]     status_d
);
  localparam int CIW = $clog2(N_CRIT);
  localparam int MIW = $clog2(N_MAIN);
  localparam int PIW = $clog2(N_PER);

  logic              dma_hit;
  logic [N_PER-1:0]  p_src, p_act, p_hi, p_lo;
  logic [N_CRIT-1:0] c_src, c_act;
  logic [N_MAIN-1:0] m_src, m_act;
  logic              hi_hit, lo_hit, c_hit, m_hit, p_hit;
  logic [PIW-1:0]    hi_idx, lo_idx, p_idx;
  logic [CIW-1:0]    c_idx;
  logic [MIW-1:0]    m_idx;

  assign dma_hit = |(dpend & ~dmask);

  always_comb begin
    p_src = per_req;
    p_src[PER_CASCADE] = dma_hit;
  end

  genvar n;
  generate
    for (n = 0; n < N_PER; n++) begin : g_per
      assign p_act[n] = p_src[n] & ~pmask[N_PER-1-n];
    end
    for (n = 0; n < N_MAIN; n++) begin : g_main
      assign m_act[n] = m_src[n] & ~mmask[N_MAIN-1-n];
    end
  endgenerate

  assign p_hi = p_act & pclass;
  assign p_lo = p_act & ~pclass;

  irq_lowfirst #(.N(N_PER), .IW(PIW)) u_phi (
    .clk(clk), .rst(rst), .req(p_hi), .hit(hi_hit), .idx(hi_idx));
  irq_lowfirst #(.N(N_PER), .IW(PIW)) u_plo (
    .clk(clk), .rst(rst), .req(p_lo), .hit(lo_hit), .idx(lo_idx));

  always_comb begin
    c_src = crit_req;
    c_src[CRIT_REDIR] = hi_hit;
  end
  always_comb begin
    m_src = main_req;
    m_src[MAIN_REDIR] = lo_hit;
  end
  assign c_act = c_src & ~cmask;

  irq_lowfirst #(.N(N_CRIT), .IW(CIW)) u_crit (
    .clk(clk), .rst(rst), .req(c_act), .hit(c_hit), .idx(c_idx));
  irq_lowfirst #(.N(N_MAIN), .IW(MIW)) u_main (
    .clk(clk), .rst(rst), .req(m_act), .hit(m_hit), .idx(m_idx));

  assign p_hit = hi_hit | lo_hit;
  assign p_idx = hi_hit ? hi_idx : lo_idx;

  always_comb begin
    status_d = '0;
    status_d[CRIT_FLAG] = c_hit;
    status_d[MAIN_FLAG] = m_hit;
    status_d[PER_FLAG]  = p_hit;
    if (c_hit) status_d[CRIT_LSB +: CIW] = c_idx;
    if (m_hit) status_d[MAIN_LSB +: MIW] = m_idx;
    if (p_hit) status_d[PER_LSB +: PIW]  = p_idx;
  end

  // R6: a redirect slot always has a peripheral winner behind it
  a_r6_crit_redirect: assert property (@(posedge clk) disable iff (rst)
    (c_hit && c_idx == CIW'(CRIT_REDIR)) |-> (p_hit && pclass[p_idx]));
  a_r6_main_redirect: assert property (@(posedge clk) disable iff (rst)
    (m_hit && m_idx == MIW'(MAIN_REDIR)) |-> lo_hit);
  // R7: cascade slot reported only with an unmasked DMA pending bit
  a_r7_cascade: assert property (@(posedge clk) disable iff (rst)
    (p_hit && p_idx == PIW'(PER_CASCADE)) |-> ((dpend & ~dmask) != '0));
  // R3: a reported source is never masked
  a_r3_main_unmasked: assert property (@(posedge clk) disable iff (rst)
    m_hit |-> !mmask[MIW'(N_MAIN-1) - m_idx]);
  a_r3_per_unmasked: assert property (@(posedge clk) disable iff (rst)
    p_hit |-> !pmask[PIW'(N_PER-1) - p_idx]);
endmodule

// File: rtl/irq_status_enc.sv
module irq_status_enc
  import irq_enc_pkg::*;
#(
  parameter int N_CRIT = 4,
  parameter int N_MAIN = 17,
  parameter int N_PER  = 32,
  parameter int N_DMA  = 32,
  parameter int DW     = 32,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CRIT-1:0] crit_req,
  input  logic [N_MAIN-1:0] main_req,
  input  logic [N_PER-1:0]  per_req,
  input  logic [N_DMA-1:0]  dma_req,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq_o,
  output logic              crit_o
);
  logic [N_CRIT-1:0] cmask;
  logic [N_MAIN-1:0] mmask;
  logic [N_PER-1:0]  pmask, pclass;
  logic [N_DMA-1:0]  dmask, dpend;
  logic [DW-1:0]     status_d;
  logic              any_flag;

  irq_regs #(.N_CRIT(N_CRIT), .N_MAIN(N_MAIN), .N_PER(N_PER), .N_DMA(N_DMA),
             .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .dma_req(dma_req), .status_d(status_d),
    .cmask(cmask), .mmask(mmask), .pmask(pmask), .dmask(dmask),
    .dpend(dpend), .pclass(pclass), .rdata(rdata));

  irq_tiers #(.N_CRIT(N_CRIT), .N_MAIN(N_MAIN), .N_PER(N_PER), .N_DMA(N_DMA),
              .DW(DW)) u_tiers (
    .clk(clk), .rst(rst), .crit_req(crit_req), .main_req(main_req),
    .per_req(per_req), .cmask(cmask), .mmask(mmask), .pmask(pmask),
    .dmask(dmask), .dpend(dpend), .pclass(pclass), .status_d(status_d));

  assign any_flag = status_d[CRIT_FLAG] | status_d[MAIN_FLAG] | status_d[PER_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      crit_o <= 1'b0;
    end else begin
      irq_o  <= any_flag;
      crit_o <= status_d[CRIT_FLAG];
    end
  end

  // R9: outputs track the status flags one cycle later
  a_r9_crit_implies_irq: assert property (@(posedge clk) disable iff (rst)
    crit_o |-> irq_o);
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past(any_flag)));
endmodule

// File: tb/test_irq_status_enc.sv
module test_irq_status_enc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  crit_req = '0;
  logic [16:0] main_req = '0;
  logic [31:0] per_req = '0;
  logic [31:0] dma_req = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, crit_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [3:0]  m_cmask;
  logic [16:0] m_mmask;
  logic [31:0] m_pmask, m_dmask, m_dpend, m_class;

  always #5 clk = ~clk;

  irq_status_enc i_irq_status_enc (
    .clk(clk), .rst(rst), .crit_req(crit_req), .main_req(main_req),
    .per_req(per_req), .dma_req(dma_req), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .crit_o(crit_o));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd1: m_cmask = d[3:0];
      3'd2: m_mmask = d[16:0];
      3'd3: m_pmask = d;
      3'd4: m_dmask = d;
      3'd5: m_dpend = m_dpend & ~d;
      3'd6: m_class = d;
      default: ;
    endcase
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic dma_pulse(input logic [31:0] v);
    @(negedge clk);
    dma_req = v;
    @(negedge clk);
    dma_req = '0;
    m_dpend = m_dpend | v;
  endtask

  function automatic logic [31:0] exp_status();
    logic dma_any, hi_f, lo_f, c_f, m_f, src;
    int hi_i, lo_i, c_i, m_i, p_i;
    logic [31:0] s;
    dma_any = |(m_dpend & ~m_dmask);
    hi_f = 1'b0; lo_f = 1'b0; hi_i = 0; lo_i = 0;
    for (int n = 0; n < 32; n++) begin
      src = (n == 0) ? dma_any : per_req[n];
      if (src && !m_pmask[31-n]) begin
        if (m_class[n]) begin
          if (!hi_f) begin hi_f = 1'b1; hi_i = n; end
        end else begin
          if (!lo_f) begin lo_f = 1'b1; lo_i = n; end
        end
      end
    end
    c_f = 1'b0; c_i = 0;
    for (int n = 0; n < 4; n++) begin
      src = (n == 2) ? hi_f : crit_req[n];
      if (src && !m_cmask[n] && !c_f) begin c_f = 1'b1; c_i = n; end
    end
    m_f = 1'b0; m_i = 0;
    for (int n = 0; n < 17; n++) begin
      src = (n == 4) ? lo_f : main_req[n];
      if (src && !m_mmask[16-n] && !m_f) begin m_f = 1'b1; m_i = n; end
    end
    p_i = hi_f ? hi_i : lo_i;
    s = '0;
    if (c_f) s = s | 32'h400 | (32'(c_i) << 8);
    if (m_f) s = s | 32'h0020_0000 | (32'(m_i) << 16);
    if (hi_f || lo_f) s = s | 32'h2000_0000 | (32'(p_i) << 24);
    return s;
  endfunction

  task automatic check_status(input string req);
    logic [31:0] s, e;
    repeat (2) @(negedge clk);
    reg_rd(3'd0, s);
    e = exp_status();
    check(req, s, e);
    check({req, " irq_o (R9)"}, {31'b0, irq_o}, {31'b0, e[10] | e[21] | e[29]});
    check({req, " crit_o (R9)"}, {31'b0, crit_o}, {31'b0, e[10]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1977));
    m_cmask = 4'hF; m_mmask = 17'h10FFF; m_pmask = 32'h7FFFFC00;
    m_dmask = '1; m_dpend = '0; m_class = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    check("R1 irq_o", {31'b0, irq_o}, 32'h0);
    check("R1 crit_o", {31'b0, crit_o}, 32'h0);
    reg_rd(3'd1, d); check("R1 cmask", d, 32'hF);
    reg_rd(3'd2, d); check("R1 mmask", d, 32'h0001_0FFF);
    reg_rd(3'd3, d); check("R1 pmask", d, 32'h7FFF_FC00);
    reg_rd(3'd4, d); check("R1 dmask", d, 32'hFFFF_FFFF);
    reg_rd(3'd5, d); check("R1 dpend", d, 32'h0);
    reg_rd(3'd6, d); check("R1 class", d, 32'h0);
    // R10 unused address
    reg_rd(3'd7, d); check("R10 addr7", d, 32'h0);
    // R10 only implemented mask bits retained
    reg_wr(3'd1, 32'hFFFF_FFF0); reg_rd(3'd1, d); check("R10 cmask width", d, 32'h0);
    reg_wr(3'd2, 32'hFFFE_0000); reg_rd(3'd2, d); check("R10 mmask width", d, 32'h0);
    reg_wr(3'd3, 32'h0);

    // R5 internal slots ignore their inputs
    crit_req = 4'b0100; main_req = 17'h10; per_req = 32'h1;
    check_status("R5 ignored inputs");
    reg_rd(3'd0, d); check("R5 status zero", d, 32'h0);

    // R2 / R4 critical layout, lowest wins
    crit_req = 4'b1010; main_req = '0; per_req = '0;
    check_status("R4 crit");
    reg_rd(3'd0, d); check("R2 crit field", d, 32'h0000_0500);
    crit_req = '0;

    // R7 cascade gated by DMA mask
    dma_pulse(32'h20);
    reg_rd(3'd0, d); check("R7 masked dma", d, 32'h0);
    reg_wr(3'd4, ~32'h20);
    check_status("R7 cascade");
    reg_rd(3'd0, d); check("R7 slot0 main4", d, 32'h2024_0000);

    // R6 high class redirects to critical slot 2
    reg_wr(3'd6, 32'h1);
    check_status("R6 high class");
    reg_rd(3'd0, d); check("R6 crit2", d, 32'h2000_0600);
    reg_wr(3'd6, 32'h0);

    // R8 write zero has no effect, set wins over clear
    reg_wr(3'd5, 32'h0); reg_rd(3'd5, d); check("R8 write0", d, 32'h20);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd5; wdata = 32'h20; dma_req = 32'h20;
    @(negedge clk);
    wr_en = 1'b0; dma_req = '0;
    reg_rd(3'd5, d); check("R8 set wins", d, 32'h20);
    reg_wr(3'd5, 32'hFFFF_FFFF); reg_rd(3'd5, d); check("R8 clear all", d, 32'h0);

    // R10 status write ignored
    crit_req = 4'b0001;
    reg_wr(3'd0, 32'hFFFF_FFFF);
    check_status("R10 status write");
    reg_rd(3'd3, d); check("R10 pmask kept", d, 32'h0);
    crit_req = '0;

    // R3 peripheral bit reversal
    reg_wr(3'd3, ~(32'h1 << 24));
    per_req = 32'h88;
    check_status("R3 per mask");
    reg_rd(3'd0, d); check("R3 per source 7", d, 32'h2724_0000);
    per_req = '0;

    // Random mix
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 4) == 0) reg_wr(3'd1, $urandom);
      if (($urandom % 4) == 0) reg_wr(3'd2, $urandom & $urandom);
      if (($urandom % 4) == 0) reg_wr(3'd3, $urandom | $urandom);
      if (($urandom % 4) == 0) reg_wr(3'd4, $urandom | $urandom);
      if (($urandom % 5) == 0) reg_wr(3'd6, $urandom);
      if (($urandom % 3) == 0) dma_pulse($urandom & $urandom & $urandom);
      if (($urandom % 4) == 0) reg_wr(3'd5, $urandom);
      crit_req = 4'($urandom & $urandom);
      main_req = 17'($urandom & $urandom & $urandom);
      per_req  = $urandom & $urandom & $urandom;
      check_status("R4 random");
      if (($urandom % 8) == 0) begin
        reg_rd(3'd5, d); check("R8 random pend", d, m_dpend);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule